// File: doc/BRIEF.md
# Barrel Shifter with Shifter Carry-Out

A purely combinational shifter for a 32-bit datapath. One operand is moved left, moved right with zero fill, moved right with sign fill, rotated right, or rotated right by one place through the incoming carry flag. The block returns the shifted word together with the shifter carry-out that the flag logic of an arithmetic unit consumes when it updates its carry flag on logical operations.

The shift amount is an 8-bit count, so it can exceed the word width. The block treats a count of zero, a count equal to the width, and a count above the width as distinct cases with exact result and carry rules. Rotation uses only the count modulo 32 for its result. The block has no clock and no reset, and it holds no state. It has no state machine. The operation code is decoded once into a named operation, and each named operation selects one output path.

Top module: `barrel_shift_unit`

## Requirements
- R1: For operation codes 0 to 3, and for codes 5 to 7, a count of 0 returns the operand unchanged on `res_o`, and `cout_o` equals `cin_i`.
- R2: Operation code 0 is a left shift. For a count n from 1 to 31, `res_o` is the operand shifted left by n with zeros filling from the bottom, and `cout_o` is operand bit 32−n.
- R3: For a left shift with n = 32, `res_o` is 0 and `cout_o` is operand bit 0. For n above 32, both `res_o` and `cout_o` are 0.
- R4: Operation code 1 is a right shift with zero fill. For n from 1 to 31, `res_o` is the operand shifted right by n, and `cout_o` is operand bit n−1.
- R5: For a zero-fill right shift with n = 32, `res_o` is 0 and `cout_o` is operand bit 31. For n above 32, both outputs are 0.
- R6: Operation code 2 is a right shift with sign fill. For n from 1 to 31, `cout_o` is operand bit n−1. For n of 32 or more, every bit of `res_o` equals operand bit 31, and `cout_o` equals operand bit 31.
- R7: Operation code 3 is a rotate right. For a nonzero count, the operand is rotated right by n mod 32 and `cout_o` is bit 31 of `res_o`. A nonzero multiple of 32 therefore returns the operand unchanged, with `cout_o` equal to operand bit 31.
- R8: Operation code 4 is a one-place rotate through carry, and it ignores the count. `res_o` is {`cin_i`, operand[31:1]}, and `cout_o` is operand bit 0.
- R9: Operation codes 5, 6 and 7 give exactly the outputs of code 0 for every operand, count and carry.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opnd_i | input | 32 | Operand to shift |
| amt_i | input | 8 | Shift count, 0 to 255 |
| op_i | input | 3 | Operation code (0 left, 1 right zero-fill, 2 right sign-fill, 3 rotate, 4 rotate through carry, 5 to 7 left) |
| cin_i | input | 1 | Incoming carry flag |
| res_o | output | 32 | Shifted result |
| cout_o | output | 1 | Shifter carry-out |

## Verification
The assertions re-evaluate on every change of the inputs. They cover five things: the pass-through at a zero count, the all-zero outputs when a left or zero-fill right shift goes past the width, the sign replication of a sign-fill shift that runs off the end, the carry of the rotate (always bit 31 of the result), and the bit movement of the rotate through carry. The exact carry bit chosen for counts 1 to 32, the rotation amount for counts that are not multiples of 32, and the equivalence of the spare operation codes with the left shift can only be shown by the bench. The bench sweeps every count from 0 to 255 against its own reference model.

// File: rtl/bsh_pkg.sv
package bsh_pkg;

    typedef enum logic [2:0] {
        OP_SHL  = 3'd0,
        OP_SHR  = 3'd1,
        OP_SAR  = 3'd2,
        OP_ROTR = 3'd3,
        OP_ROTX = 3'd4
    } shop_e;

    // Spare codes fold onto the left shift.
    function automatic shop_e decode_op(input logic [2:0] code);
        shop_e d;
        unique case (code)
            3'd1:    d = OP_SHR;
            3'd2:    d = OP_SAR;
            3'd3:    d = OP_ROTR;
            3'd4:    d = OP_ROTX;
            default: d = OP_SHL;
        endcase
        return d;
    endfunction

endpackage

// File: rtl/bsh_amt_class.sv
module bsh_amt_class #(
    parameter int WIDTH = 32,
    parameter int AMT_W = 8,
    localparam int SH_W = $clog2(WIDTH)
) (
    input  logic [AMT_W-1:0] amt_i,
    output logic             zero_o,
    output logic             below_o,
    output logic             equal_o,
    output logic [SH_W-1:0]  low_o
);
    localparam logic [AMT_W-1:0] WIDTH_AMT = AMT_W'(WIDTH);

    always_comb begin
        zero_o  = (amt_i == '0);
        below_o = (amt_i < WIDTH_AMT);
        equal_o = (amt_i == WIDTH_AMT);
        low_o   = amt_i[SH_W-1:0];
    end
endmodule

// File: rtl/bsh_bitrev.sv
module bsh_bitrev #(
    parameter int WIDTH = 32
) (
    input  logic [WIDTH-1:0] d_i,
    output logic [WIDTH-1:0] q_o
);
    for (genvar b = 0; b < WIDTH; b++) begin : g_rev
        assign q_o[b] = d_i[WIDTH-1-b];
    end
endmodule

// File: rtl/bsh_funnel.sv
// Logarithmic right funnel over {upper, lower, guard}. The guard bit
// catches the last bit shifted out of the lower word.
module bsh_funnel #(
    parameter int WIDTH = 32,
    localparam int SH_W = $clog2(WIDTH),
    localparam int FW   = 2 * WIDTH + 1
) (
    input  logic [WIDTH-1:0] upper_i,
    input  logic [WIDTH-1:0] lower_i,
    input  logic [SH_W-1:0]  k_i,
    output logic [WIDTH-1:0] res_o,
    output logic             out_bit_o
);
    logic [FW-1:0] stage [SH_W+1];

    assign stage[0] = {upper_i, lower_i, 1'b0};

    for (genvar s = 0; s < SH_W; s++) begin : g_stage
        assign stage[s+1] = k_i[s] ? (stage[s] >> (1 << s)) : stage[s];
    end

    logic [FW-1:0] last;
    assign last      = stage[SH_W];
    assign res_o     = last[WIDTH:1];
    assign out_bit_o = last[0];

    logic unused_hi;
    assign unused_hi = ^last[FW-1:WIDTH+1];
endmodule

// File: rtl/barrel_shift_unit.sv
module barrel_shift_unit
    import bsh_pkg::*;
#(
    parameter int WIDTH = 32,
    parameter int AMT_W = 8,
    localparam int SH_W = $clog2(WIDTH)
) (
    input  logic [WIDTH-1:0] opnd_i,
    input  logic [AMT_W-1:0] amt_i,
    input  logic [2:0]       op_i,
    input  logic             cin_i,
    output logic [WIDTH-1:0] res_o,
    output logic             cout_o
);
    shop_e            op_d;
    logic             amt_zero, amt_below, amt_equal;
    logic [SH_W-1:0]  amt_low;
    logic [WIDTH-1:0] opnd_rev, fun_lower, fun_upper, fun_res, fun_res_rev;
    logic             fun_bit;
    logic             sign;

    assign op_d = decode_op(op_i);
    assign sign = opnd_i[WIDTH-1];

    bsh_amt_class #(.WIDTH(WIDTH), .AMT_W(AMT_W)) amt_cls_i (
        .amt_i  (amt_i),
        .zero_o (amt_zero),
        .below_o(amt_below),
        .equal_o(amt_equal),
        .low_o  (amt_low)
    );

    bsh_bitrev #(.WIDTH(WIDTH)) rev_in_i (
        .d_i(opnd_i),
        .q_o(opnd_rev)
    );

    // Left shifts run through the right funnel on the mirrored word.
    always_comb begin
        fun_lower = (op_d == OP_SHL) ? opnd_rev : opnd_i;
        unique case (op_d)
            OP_SAR:  fun_upper = {WIDTH{sign}};
            OP_ROTR: fun_upper = opnd_i;
            default: fun_upper = '0;
        endcase
    end

    bsh_funnel #(.WIDTH(WIDTH)) funnel_i (
        .upper_i  (fun_upper),
        .lower_i  (fun_lower),
        .k_i      (amt_low),
        .res_o    (fun_res),
        .out_bit_o(fun_bit)
    );

    bsh_bitrev #(.WIDTH(WIDTH)) rev_out_i (
        .d_i(fun_res),
        .q_o(fun_res_rev)
    );

    always_comb begin
        res_o  = opnd_i;
        cout_o = cin_i;
        unique case (op_d)
            OP_ROTX: begin
                res_o  = {cin_i, opnd_i[WIDTH-1:1]};
                cout_o = opnd_i[0];
            end
            OP_ROTR: begin
                if (!amt_zero) begin
                    if (amt_low == '0) begin
                        res_o  = opnd_i;
                        cout_o = sign;
                    end else begin
                        res_o  = fun_res;
                        cout_o = fun_res[WIDTH-1];
                    end
                end
            end
            OP_SHL: begin
                if (!amt_zero) begin
                    if (amt_below) begin
                        res_o  = fun_res_rev;
                        cout_o = fun_bit;
                    end else begin
                        res_o  = '0;
                        cout_o = amt_equal & opnd_i[0];
                    end
                end
            end
            OP_SHR: begin
                if (!amt_zero) begin
                    if (amt_below) begin
                        res_o  = fun_res;
                        cout_o = fun_bit;
                    end else begin
                        res_o  = '0;
                        cout_o = amt_equal & sign;
                    end
                end
            end
            OP_SAR: begin
                if (!amt_zero) begin
                    if (amt_below) begin
                        res_o  = fun_res;
                        cout_o = fun_bit;
                    end else begin
                        res_o  = {WIDTH{sign}};
                        cout_o = sign;
                    end
                end
            end
            default: begin
                res_o  = opnd_i;
                cout_o = cin_i;
            end
        endcase
    end
endmodule

// File: rtl/barrel_shift_unit_chk.sv
module barrel_shift_unit_chk #(
    parameter int WIDTH = 32,
    parameter int AMT_W = 8
) (
    input logic [WIDTH-1:0] opnd_i,
    input logic [AMT_W-1:0] amt_i,
    input logic [2:0]       op_i,
    input logic             cin_i,
    input logic [WIDTH-1:0] res_o,
    input logic             cout_o
);
    localparam int LIMIT = WIDTH;
    logic is_left, is_over;

    always_comb begin
        is_left = (op_i == 3'd0) || (op_i > 3'd4);
        is_over = (int'(amt_i) > LIMIT);

        assert_zero_pass_R1: assert ((op_i == 3'd4) || (amt_i != '0)
                                     || (res_o == opnd_i && cout_o == cin_i))
            else $error("zero count did not pass operand through");

        // R3 and R5: past the width both left and zero-fill right shifts are all zero
        assert_over_clear_R3: assert (!((is_left || op_i == 3'd1) && is_over)
                                      || (res_o == '0 && cout_o == 1'b0))
            else $error("shift beyond width left nonzero outputs");

        assert_sign_fill_R6: assert (!(op_i == 3'd2 && int'(amt_i) >= LIMIT)
                                     || (res_o == {WIDTH{opnd_i[WIDTH-1]}}
                                         && cout_o == opnd_i[WIDTH-1]))
            else $error("sign-fill shift past width not replicated");

        assert_rot_carry_R7: assert (!(op_i == 3'd3 && amt_i != '0)
                                     || cout_o == res_o[WIDTH-1])
            else $error("rotate carry differs from result top bit");

        assert_rotx_move_R8: assert (op_i != 3'd4
                                     || (res_o[WIDTH-1] == cin_i
                                         && cout_o == opnd_i[0]
                                         && res_o[WIDTH-2:0] == opnd_i[WIDTH-1:1]))
            else $error("rotate through carry moved bits wrongly");
    end
endmodule

bind barrel_shift_unit barrel_shift_unit_chk #(.WIDTH(WIDTH), .AMT_W(AMT_W)) chk_i (
    .opnd_i(opnd_i),
    .amt_i (amt_i),
    .op_i  (op_i),
    .cin_i (cin_i),
    .res_o (res_o),
    .cout_o(cout_o)
);

// File: tb/barrel_shift_unit_tb_top.sv
module barrel_shift_unit_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 150000;

    logic        clk = 1'b0;
    logic [31:0] opnd = '0;
    logic [7:0]  amt  = '0;
    logic [2:0]  op   = '0;
    logic        cin  = 1'b0;
    logic [31:0] res;
    logic        cout;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    barrel_shift_unit dut_i (
        .opnd_i(opnd), .amt_i(amt), .op_i(op), .cin_i(cin),
        .res_o(res), .cout_o(cout)
    );

    // Independent reference model, bit by bit from the requirements.
    function automatic logic [32:0] model(input logic [2:0] o, input logic [31:0] a,
                                          input int n, input logic c);
        logic [31:0] r;
        logic        co;
        int          k;
        r  = a;
        co = c;
        if (o == 3'd4) begin
            r  = {c, a[31:1]};
            co = a[0];
        end else if (n != 0) begin
            if (o == 3'd1) begin
                for (int i = 0; i < 32; i++) r[i] = (i + n < 32) ? a[i+n] : 1'b0;
                co = (n <= 32) ? a[n-1] : 1'b0;
            end else if (o == 3'd2) begin
                for (int i = 0; i < 32; i++) r[i] = (i + n < 32) ? a[i+n] : a[31];
                co = (n <= 32) ? a[n-1] : a[31];
            end else if (o == 3'd3) begin
                k = n % 32;
                for (int i = 0; i < 32; i++) r[i] = a[(i+k)%32];
                co = r[31];
            end else begin
                for (int i = 0; i < 32; i++) r[i] = (i >= n) ? a[i-n] : 1'b0;
                co = (n <= 32) ? a[32-n] : 1'b0;
            end
        end
        return {co, r};
    endfunction

    task automatic apply_check(input string req, input logic [2:0] o,
                               input logic [31:0] a, input int n, input logic c,
                               input logic [32:0] exp);
        op = o; opnd = a; amt = 8'(n); cin = c;
        #(CLK_PERIOD/2);
        n_checks++;
        if ({cout, res} !== exp) begin
            n_fail++;
            $display("FAIL %s op=%0d amt=%0d res=%h exp=%h cout=%b exp=%b",
                     req, o, n, res, exp[31:0], cout, exp[32]);
        end
    endtask

    task automatic t_zero_count;   // R1
        for (int o = 0; o < 8; o++) begin
            if (o == 4) continue;
            apply_check("R1", 3'(o), 32'hA5C3_0F81, 0, 1'b1, {1'b1, 32'hA5C3_0F81});
            apply_check("R1", 3'(o), 32'h8000_0001, 0, 1'b0, {1'b0, 32'h8000_0001});
        end
    endtask

    task automatic t_left_fixed;   // R2, R3
        apply_check("R2", 3'd0, 32'h8000_0001, 1, 1'b0, {1'b1, 32'h0000_0002});
        apply_check("R2", 3'd0, 32'h0000_0001, 31, 1'b1, {1'b0, 32'h8000_0000});
        apply_check("R3", 3'd0, 32'h0000_0001, 32, 1'b0, {1'b1, 32'h0});
        apply_check("R3", 3'd0, 32'hFFFF_FFFF, 33, 1'b1, {1'b0, 32'h0});
    endtask

    task automatic t_right_fixed;  // R4, R5, R6
        apply_check("R4", 3'd1, 32'h8000_0001, 1, 1'b0, {1'b1, 32'h4000_0000});
        apply_check("R5", 3'd1, 32'h8000_0000, 32, 1'b0, {1'b1, 32'h0});
        apply_check("R5", 3'd1, 32'hFFFF_FFFF, 200, 1'b1, {1'b0, 32'h0});
        apply_check("R6", 3'd2, 32'h8000_0002, 2, 1'b0, {1'b1, 32'hE000_0000});
        apply_check("R6", 3'd2, 32'h8000_0000, 32, 1'b0, {1'b1, 32'hFFFF_FFFF});
        apply_check("R6", 3'd2, 32'h7FFF_FFFF, 255, 1'b1, {1'b0, 32'h0});
    endtask

    task automatic t_rotate_fixed; // R7, R8
        apply_check("R7", 3'd3, 32'h0000_0001, 1, 1'b0, {1'b1, 32'h8000_0000});
        apply_check("R7", 3'd3, 32'h8000_0001, 32, 1'b0, {1'b1, 32'h8000_0001});
        apply_check("R7", 3'd3, 32'h1234_5678, 64, 1'b1, {1'b0, 32'h1234_5678});
        apply_check("R7", 3'd3, 32'h1234_5678, 36, 1'b0, {1'b1, 32'h8123_4567});
        apply_check("R8", 3'd4, 32'h0000_0003, 0, 1'b1, {1'b1, 32'h8000_0001});
        apply_check("R8", 3'd4, 32'h0000_0002, 77, 1'b0, {1'b0, 32'h0000_0001});
    endtask

    task automatic t_sweep(input string req, input logic [2:0] o);
        logic [31:0] a;
        logic        c;
        for (int n = 0; n < 256; n++) begin
            a = $urandom();
            c = 1'($urandom());
            apply_check(req, o, a, n, c, model(o, a, n, c));
        end
    endtask

    initial begin
        #(CLK_PERIOD/2);
        t_zero_count();
        t_left_fixed();
        t_right_fixed();
        t_rotate_fixed();
        t_sweep("R2", 3'd0);
        t_sweep("R4", 3'd1);
        t_sweep("R6", 3'd2);
        t_sweep("R7", 3'd3);
        t_sweep("R8", 3'd4);
        t_sweep("R9", 3'd5);
        t_sweep("R9", 3'd6);
        t_sweep("R9", 3'd7);
        done = 1;
    end

    initial begin
        int cyc;
        cyc = 0;
        while (!done && cyc < WATCHDOG) begin
            @(posedge clk);
            cyc++;
        end
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog expired, act=hung exp=finished");
        end
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule